// File: doc/BRIEF.md
# MDIO Management Target Responder

This block is the station end of a two-wire serial management bus. A master supplies the management clock and a shared data line. The block oversamples both with the local clock and finds the rising edges of the management clock. On each of those edges it takes one bit from the line. It waits for a run of at least 32 ones and then for the start pattern. After that it collects the opcode, the device address and the register address, and serves the frame from an internal bank of 32 sixteen-bit registers.

Writes are stored once the last data bit has arrived. Reads are answered on the shared line. The block releases the line for the first turnaround bit and pulls it low for the second. It then shifts out the register contents, most significant bit first, one bit per management clock period, and releases the line afterwards. A frame addressed to another device leaves the block silent. The device address comes from strap inputs. The line is split into an input, an output value and an output enable, so the pad or an external tristate buffer forms the bidirectional pin with a pull-up.

Top module: `mdio_target`

## Requirements
- R1: While `rst` is high, and in the first clock after it, `mdio_oe` is 0. Any frame in progress is dropped, and a new frame again needs a full preamble.
- R2: A frame is recognised only after at least 32 consecutive ones sampled on `mdc` rising edges, followed by a 0 and then a 1. A run of 31 ones followed by that pattern is ignored.
- R3: After the start pattern come the 2-bit opcode, the 5-bit device address and the 5-bit register address, each most significant bit first. Opcode 01 is a write and opcode 10 is a read. Opcodes 00 and 11 are ignored. All 32 register addresses, including 0 and 31, are served.
- R4: If the device address differs from `strap_addr`, the frame is ignored. The register bank is unchanged, and `mdio_oe` stays 0 for the whole frame.
- R5: A write commits its 16 data bits, sent most significant bit first, to the addressed register only after the 16th data bit. A frame cut short by reset leaves the register unchanged. `mdio_oe` stays 0 throughout a write, including its turnaround bits.
- R6: In a read, `mdio_oe` is 0 during the first turnaround bit period. During the second turnaround bit period, `mdio_oe` is 1 and `mdio_o` is 0.
- R7: Read data goes out most significant bit first. Each bit is launched shortly after the `mdc` rising edge that samples the preceding bit and is held for one full `mdc` period. `mdio_o` and `mdio_oe` change only in response to an `mdc` rising edge.
- R8: `mdio_oe` returns to 0 after the rising edge that samples the last read data bit, so the line is back on the pull-up for the following bit period.
- R9: After any frame ends, the preamble count restarts from zero. A following frame therefore needs its own run of at least 32 ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local oversampling clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_addr | input | 5 | Device address this target answers to |
| mdc | input | 1 | Management clock from the master |
| mdio_i | input | 1 | Sampled level of the shared data line |
| mdio_o | output | 1 | Value driven onto the data line when enabled |
| mdio_oe | output | 1 | Output enable for the data line |

## Verification
Four properties are checked on every clock: the line is released during and just after reset, the outputs move only after a detected `mdc` rising edge, every enable of the line starts with a driven zero, and a register write never coincides with the line being driven. The scenarios alone can show the framing behaviour: preamble length, opcode and address filtering, bit order of write and read data, the acknowledge seen at the second turnaround bit, and the release after the last data bit. The bench keeps its own register mirror and compares the target's outputs with its expected output sequence in every bit period. The same scenarios also show that a write cut short by reset leaves storage untouched.

// File: rtl/mdio_tgt_pkg.sv
package mdio_tgt_pkg;

  typedef enum logic [2:0] {
    S_HUNT,   // counting preamble ones
    S_START,  // saw the 0 of the start pattern
    S_OPC,    // opcode bits
    S_ADDR,   // device + register address bits
    S_WTA,    // write turnaround, master drives
    S_WDAT,   // write data bits
    S_RTA,    // read turnaround, target answers
    S_RDAT    // read data bits
  } tgt_state_e;

  localparam logic [1:0] OPC_WRITE = 2'b01;
  localparam logic [1:0] OPC_READ  = 2'b10;

endpackage

// File: rtl/mdio_edge_sync.sv
module mdio_edge_sync #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic mdc,
  input  logic mdio_i,
  output logic rise,
  output logic bit_o
);
  logic [SYNC:0]   mdc_q;
  logic [SYNC-1:0] dat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mdc_q <= '0;
      dat_q <= '1;
    end else begin
      mdc_q <= {mdc_q[SYNC-1:0], mdc};
      dat_q <= {dat_q[SYNC-2:0], mdio_i};
    end
  end

  // data and clock pass through the same depth, so they stay aligned
  assign rise  = mdc_q[SYNC-1] & ~mdc_q[SYNC];
  assign bit_o = dat_q[SYNC-1];
endmodule

// File: rtl/mdio_regfile.sv
module mdio_regfile #(
  parameter int AW = 5,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
  import mdio_tgt_pkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int AW      = 5,
  parameter int DW      = 16,
  parameter int PAW     = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           rise,
  input  logic           bit_i,
  input  logic [PAW-1:0] strap,
  input  logic [DW-1:0]  rd_data,
  output logic [AW-1:0]  reg_addr,
  output logic           wr_en,
  output logic [DW-1:0]  wr_data,
  output logic           mdio_o,
  output logic           mdio_oe
);
  localparam int AL   = PAW + AW;
  localparam int CMAX = (AL > DW) ? AL : DW;
  localparam int CW   = $clog2(CMAX + 1);
  localparam int PCW  = $clog2(PRE_LEN + 1);
  localparam logic [PCW-1:0] PRE_FULL  = PCW'(PRE_LEN);
  localparam logic [CW-1:0]  C_ONE     = CW'(1);
  localparam logic [CW-1:0]  C_ADDR_LS = CW'(AL - 1);
  localparam logic [CW-1:0]  C_DAT_LS  = CW'(DW - 1);
  localparam logic [CW-1:0]  C_DAT_END = CW'(DW);

  tgt_state_e     st;
  logic [PCW-1:0] ones;
  logic [CW-1:0]  cnt;
  logic [1:0]     opc;
  logic [AL-1:0]  addr_sh;
  logic [DW-1:0]  dsh;
  logic [AL-1:0]  addr_nx;
  logic           dev_hit;

  assign addr_nx  = {addr_sh[AL-2:0], bit_i};
  assign dev_hit  = (addr_nx[AL-1:AW] == strap);
  assign reg_addr = addr_sh[AW-1:0];
  assign wr_data  = dsh;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_HUNT;
      ones    <= '0;
      cnt     <= '0;
      opc     <= '0;
      addr_sh <= '0;
      dsh     <= '0;
      wr_en   <= 1'b0;
      mdio_oe <= 1'b0;
      mdio_o  <= 1'b1;
    end else begin
      wr_en <= 1'b0;
      if (rise) begin
        unique case (st)
          S_HUNT: begin
            if (bit_i) begin
              if (ones != PRE_FULL) ones <= ones + 1'b1;
            end else begin
              ones <= '0;
              if (ones == PRE_FULL) st <= S_START;
            end
          end
          S_START: begin
            cnt <= '0;
            st  <= bit_i ? S_OPC : S_HUNT;
          end
          S_OPC: begin
            opc <= {opc[0], bit_i};
            if (cnt == C_ONE) begin
              cnt <= '0;
              st  <= S_ADDR;
            end else cnt <= cnt + 1'b1;
          end
          S_ADDR: begin
            addr_sh <= addr_nx;
            if (cnt == C_ADDR_LS) begin
              cnt <= '0;
              if (dev_hit && opc == OPC_WRITE)     st <= S_WTA;
              else if (dev_hit && opc == OPC_READ) st <= S_RTA;
              else                                 st <= S_HUNT;
            end else cnt <= cnt + 1'b1;
          end
          S_WTA: begin
            if (cnt == C_ONE) begin
              cnt <= '0;
              st  <= S_WDAT;
            end else cnt <= cnt + 1'b1;
          end
          S_WDAT: begin
            dsh <= {dsh[DW-2:0], bit_i};
            if (cnt == C_DAT_LS) begin
              wr_en <= 1'b1;
              cnt   <= '0;
              st    <= S_HUNT;
            end else cnt <= cnt + 1'b1;
          end
          S_RTA: begin
            if (cnt == '0) begin
              mdio_oe <= 1'b1;
              mdio_o  <= 1'b0;
              cnt     <= C_ONE;
            end else begin
              mdio_o <= rd_data[DW-1];
              dsh    <= {rd_data[DW-2:0], 1'b0};
              cnt    <= C_ONE;
              st     <= S_RDAT;
            end
          end
          S_RDAT: begin
            if (cnt == C_DAT_END) begin
              mdio_oe <= 1'b0;
              mdio_o  <= 1'b1;
              cnt     <= '0;
              st      <= S_HUNT;
            end else begin
              mdio_o <= dsh[DW-1];
              dsh    <= {dsh[DW-2:0], 1'b0};
              cnt    <= cnt + 1'b1;
            end
          end
          default: st <= S_HUNT;
        endcase
      end
    end
  end
endmodule

// File: rtl/mdio_target.sv
module mdio_target #(
  parameter int PRE_LEN     = 32,
  parameter int REG_AW      = 5,
  parameter int DATA_W      = 16,
  parameter int DEV_AW      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DEV_AW-1:0] strap_addr,
  input  logic              mdc,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe
);
  logic              mdc_rise;
  logic              bit_s;
  logic              wr_en;
  logic [REG_AW-1:0] reg_addr;
  logic [DATA_W-1:0] wr_data;
  logic [DATA_W-1:0] rd_data;

  mdio_edge_sync #(.SYNC(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .mdc(mdc), .mdio_i(mdio_i),
    .rise(mdc_rise), .bit_o(bit_s)
  );

  mdio_frame_fsm #(.PRE_LEN(PRE_LEN), .AW(REG_AW), .DW(DATA_W), .PAW(DEV_AW)) u_fsm (
    .clk(clk), .rst(rst), .rise(mdc_rise), .bit_i(bit_s), .strap(strap_addr),
    .rd_data(rd_data), .reg_addr(reg_addr), .wr_en(wr_en), .wr_data(wr_data),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  mdio_regfile #(.AW(REG_AW), .DW(DATA_W)) u_regs (
    .clk(clk), .we(wr_en), .waddr(reg_addr), .wdata(wr_data),
    .raddr(reg_addr), .rdata(rd_data)
  );
endmodule

// File: rtl/mdio_target_chk.sv
module mdio_target_chk (
  input logic clk,
  input logic rst,
  input logic rise,
  input logic wr_en,
  input logic mdio_oe,
  input logic mdio_o
);
  // R1
  oe_reset_chk: assert property (@(posedge clk) rst |=> !mdio_oe);

  // R7
  out_on_edge_chk: assert property (@(posedge clk) disable iff (rst)
    ((mdio_oe != $past(mdio_oe)) || (mdio_oe && mdio_o != $past(mdio_o))) |-> $past(rise));

  // R6
  ta_low_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mdio_oe) |-> !mdio_o);

  // R5
  write_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !mdio_oe);
endmodule

bind mdio_target mdio_target_chk u_chk (
  .clk(clk), .rst(rst), .rise(mdc_rise), .wr_en(wr_en),
  .mdio_oe(mdio_oe), .mdio_o(mdio_o)
);

// File: tb/sim_mdio_target.sv
module sim_mdio_target;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] strap = 5'h0B;
  logic       mdc = 1'b0;
  logic       m_drv = 1'b0;
  logic       m_val = 1'b1;
  logic       mdio_o, mdio_oe;
  wire        line_w;
  int n_chk = 0;
  int n_fail = 0;
  logic [15:0] mirror [32];

  assign line_w = mdio_oe ? mdio_o : (m_drv ? m_val : 1'b1);

  always #4 clk = ~clk;

  mdio_target u0 (
    .clk(clk), .rst(rst), .strap_addr(strap), .mdc(mdc),
    .mdio_i(line_w), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one mdc period; compares the target's outputs with the expected ones before the rise
  task automatic bit_cycle(input logic drv, input logic val, input logic eoe, input logic eo,
                           input string req, output logic seen);
    logic [1:0] act, exp;
    @(negedge clk);
    mdc = 1'b0; m_drv = drv; m_val = val;
    repeat (7) @(negedge clk);
    act = {mdio_oe, mdio_oe & mdio_o};
    exp = {eoe, eoe & eo};
    chk(act == exp, req, 32'(act), 32'(exp));
    seen = line_w;
    mdc = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic run_frame(input int npre, input logic [1:0] op, input logic [4:0] pa,
                           input logic [4:0] ra, input logic [15:0] wd, input int nbits,
                           input bit resp, input logic [15:0] ed, input string req,
                           output logic [15:0] rd, output bit ack);
    logic s;
    logic [13:0] hdr;
    rd = '0; ack = 1'b0;
    hdr = {2'b01, op, pa, ra};
    for (int i = 0; i < npre; i++) bit_cycle(1, 1, 0, 0, req, s);
    for (int i = 13; i >= 0; i--) bit_cycle(1, hdr[i], 0, 0, req, s);
    if (op == 2'b10) begin
      bit_cycle(0, 0, 0, 0, "R6", s);
      bit_cycle(0, 0, resp, 0, "R6", s);
      ack = !s;
      for (int i = 15; i >= 0; i--) begin
        bit_cycle(0, 0, resp, ed[i], "R7", s);
        rd[i] = s;
      end
      bit_cycle(0, 0, 0, 0, "R8", s);
    end else begin
      bit_cycle(1, 1, 0, 0, req, s);
      bit_cycle(1, 0, 0, 0, req, s);
      for (int i = 15; i >= 16 - nbits; i--) bit_cycle(1, wd[i], 0, 0, req, s);
    end
    m_drv = 1'b0;
  endtask

  task automatic do_write(input int npre, input logic [1:0] op, input logic [4:0] pa,
                          input logic [4:0] ra, input logic [15:0] wd, input string req);
    logic [15:0] d; bit a;
    run_frame(npre, op, pa, ra, wd, 16, 0, 16'h0, req, d, a);
    if (npre >= 32 && op == 2'b01 && pa == strap) mirror[ra] = wd;
  endtask

  task automatic do_read(input int npre, input logic [4:0] pa, input logic [4:0] ra, input string req);
    logic [15:0] d; bit a; bit resp;
    resp = (npre >= 32) && (pa == strap);
    run_frame(npre, 2'b10, pa, ra, 16'h0, 16, resp, mirror[ra], req, d, a);
    chk(a == resp, {req, " ack"}, 32'(a), 32'(resp));
    chk(d == (resp ? mirror[ra] : 16'hFFFF), {req, " data"}, 32'(d), 32'(resp ? mirror[ra] : 16'hFFFF));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] d; bit a;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(mdio_oe == 1'b0, "R1 reset", 32'(mdio_oe), 0);

    // R3 basic write and read, MSB first fields
    do_write(32, 2'b01, 5'h0B, 5'd5, 16'hA5C3, "R5 write");
    do_read(40, 5'h0B, 5'd5, "R7 read");
    // R3 boundary registers
    do_write(32, 2'b01, 5'h0B, 5'd0, 16'h0001, "R3 reg0");
    do_write(32, 2'b01, 5'h0B, 5'd31, 16'h8000, "R3 reg31");
    do_read(32, 5'h0B, 5'd0, "R3 reg0 rd");
    do_read(32, 5'h0B, 5'd31, "R3 reg31 rd");
    // R4 foreign device address
    do_write(32, 2'b01, 5'h0C, 5'd5, 16'h1111, "R4 foreign wr");
    do_read(32, 5'h0B, 5'd5, "R4 reg kept");
    do_read(32, 5'h0A, 5'd5, "R4 no ack");
    // R2 and R9: short preamble right after a completed write
    do_write(32, 2'b01, 5'h0B, 5'd7, 16'h1234, "R9 setup");
    do_write(31, 2'b01, 5'h0B, 5'd7, 16'h5678, "R2 short pre");
    do_read(32, 5'h0B, 5'd7, "R9 reg kept");
    do_write(32, 2'b01, 5'h0B, 5'd7, 16'h1234, "R9 setup2");
    do_read(31, 5'h0B, 5'd7, "R2 short read");
    // R3 invalid opcodes
    do_write(32, 2'b11, 5'h0B, 5'd7, 16'h0000, "R3 op11");
    do_write(32, 2'b00, 5'h0B, 5'd7, 16'h0F0F, "R3 op00");
    do_read(32, 5'h0B, 5'd7, "R3 op ignored");
    // R5 write cut short by reset
    run_frame(32, 2'b01, 5'h0B, 5'd7, 16'hFFFF, 8, 0, 16'h0, "R5 cut", d, a);
    @(negedge clk); rst = 1'b1; mdc = 1'b0;
    repeat (3) @(negedge clk);
    chk(mdio_oe == 1'b0, "R1 mid reset", 32'(mdio_oe), 0);
    rst = 1'b0;
    do_read(32, 5'h0B, 5'd7, "R5 reg kept");
    // R4 new strap value
    strap = 5'h1F;
    do_write(32, 2'b01, 5'h1F, 5'd3, 16'hBEEF, "R4 strap wr");
    do_read(32, 5'h1F, 5'd3, "R4 strap rd");
    do_read(32, 5'h0B, 5'd3, "R4 old strap");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule